// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block takes pixel samples from an image sensor that drives a parallel data bus together with a vertical sync, a horizontal sync and a pixel clock. All sensor pins are sampled by the system clock through a two-stage synchronizer. Edges of the pixel clock are detected in the system clock domain, so the system clock must run at least four times faster than the pixel clock. Each accepted sample goes into a small first-in first-out buffer. The sample carries a start-of-frame tag and a start-of-line tag, and a consumer drains the buffer through a simple read port.

Two capture modes are selected at run time. In gated mode a pixel clock edge counts only while horizontal sync is active, and every active horizontal sync edge opens a new line. In non-gated mode horizontal sync is ignored, and every pixel clock edge after frame start carries a sample. Vertical sync, horizontal sync and the pixel clock sampling edge each have a polarity select. A frame counter and a line counter follow the incoming stream, and a sticky flag records samples that were lost to a full buffer.

Top module: `cam_capture`

## Requirements
- R1: An active edge of vertical sync, seen while capture is enabled, starts a frame. It increments `frame_cnt` by one, clears `line_cnt`, and tags the next stored sample with start-of-frame.
- R2: Samples are discarded until the first frame start that follows the enable. Dropping `cap_en` ends the frame at once, and capture resumes only on the next frame start.
- R3: In gated mode (`gate_mode`=1) a pixel clock edge stores a sample only while horizontal sync is at its active level. Each active horizontal sync edge inside a frame increments `line_cnt` and tags the next stored sample with start-of-line.
- R4: In non-gated mode (`gate_mode`=0) horizontal sync is ignored. Every active pixel clock edge inside a frame stores a sample, the start-of-line tag stays 0, and `line_cnt` does not change.
- R5: The active level or edge is the rising one when its select is 0 and the falling one when its select is 1. This holds for `vs_inv` (vertical sync edge), `hs_inv` (horizontal sync level and edge) and `pclk_fall` (pixel clock sampling edge).
- R6: The buffer returns samples in arrival order as `rd_data` = {sof, sol, pixel}. The pixel is in bits DATA_W-1:0, sol is in bit DATA_W and sof is in bit DATA_W+1. `rd_valid` is high while the buffer holds data. `rd_en` with `rd_valid` removes one entry. A sample shows up on the read port on the third system clock edge after its pixel clock edge at the pins.
- R7: `fifo_full` is high when DEPTH entries are held. A valid sample that arrives while the buffer is full is dropped and sets `ovf_flag`. The flag holds until `ovf_clr` is pulsed, and a new overflow in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable |
| gate_mode | input | 1 | 1 = horizontal sync qualifies pixels, 0 = ignored |
| vs_inv | input | 1 | Vertical sync active edge is falling when 1 |
| hs_inv | input | 1 | Horizontal sync active level is low when 1 |
| pclk_fall | input | 1 | Sample on falling pixel clock edge when 1 |
| sen_vsync | input | 1 | Sensor vertical sync |
| sen_hsync | input | 1 | Sensor horizontal sync |
| sen_pclk | input | 1 | Sensor pixel clock |
| sen_data | input | DATA_W | Sensor pixel bus |
| rd_en | input | 1 | Pop one entry |
| rd_data | output | DATA_W+2 | Head entry {sof, sol, pixel} |
| rd_valid | output | 1 | Buffer not empty |
| fifo_full | output | 1 | Buffer holds DEPTH entries |
| ovf_flag | output | 1 | Sticky sample-loss flag |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| frame_cnt | output | CNT_W | Frames started |
| line_cnt | output | CNT_W | Lines in current frame (gated mode) |
| frame_active | output | 1 | A frame is open |

## Verification
The bench builds the block with the full 10-bit bus and a buffer depth of 4. With depth 4, the buffer fills after four pixels, so the full flag, the dropped fifth sample and the sticky overflow can be reached in a few dozen cycles. Every tag and every data bit of the wide bus is checked in the read word. A table of horizontal sync levels drives one gated frame through idle lines and several line starts. Directed runs then switch to non-gated capture, to inverted polarity on all three controls, and to enable toggling.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int unsigned LANES = 3;
    localparam int unsigned LANE_VS = 0;
    localparam int unsigned LANE_HS = 1;
    localparam int unsigned LANE_PC = 2;

    function automatic logic active_rise(input logic now_v, input logic old_v, input logic inv);
        return (now_v ^ inv) & ~(old_v ^ inv);
    endfunction

endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_in,
    input  logic              hs_in,
    input  logic              pc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              vs_inv,
    input  logic              hs_inv,
    input  logic              pc_inv,
    output logic              vs_edge,
    output logic              hs_edge,
    output logic              hs_level,
    output logic              pc_edge,
    output logic [DATA_W-1:0] data_out
);
    import cam_pkg::*;

    typedef struct packed {
        logic [LANES-1:0]  st1;
        logic [LANES-1:0]  st2;
        logic [LANES-1:0]  st3;
        logic [DATA_W-1:0] dat1;
        logic [DATA_W-1:0] dat2;
    } sync_t;

    sync_t s_d, s_q;
    logic [LANES-1:0] inv_vec;
    logic [LANES-1:0] hit;

    assign inv_vec = {pc_inv, hs_inv, vs_inv};

    always_comb begin
        s_d      = s_q;
        s_d.st1  = {pc_in, hs_in, vs_in};
        s_d.st2  = s_q.st1;
        s_d.st3  = s_q.st2;
        s_d.dat1 = data_in;
        s_d.dat2 = s_q.dat1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = active_rise(s_q.st2[g], s_q.st3[g], inv_vec[g]);
    end

    assign vs_edge  = hit[LANE_VS];
    assign hs_edge  = hit[LANE_HS];
    assign pc_edge  = hit[LANE_PC];
    assign hs_level = s_q.st2[LANE_HS] ^ hs_inv;
    assign data_out = s_q.dat2;

endmodule

// File: rtl/cam_qual.sv
module cam_qual #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned WORD_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              gate_mode,
    input  logic              vs_edge,
    input  logic              hs_edge,
    input  logic              hs_level,
    input  logic              pc_edge,
    input  logic [DATA_W-1:0] pix,
    input  logic              buf_full,
    input  logic              ovf_clr,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic              ovf,
    output logic [CNT_W-1:0]  frames,
    output logic [CNT_W-1:0]  lines,
    output logic              in_frame
);

    typedef struct packed {
        logic             open;
        logic             sof_pend;
        logic             sol_pend;
        logic             ovf;
        logic [CNT_W-1:0] frames;
        logic [CNT_W-1:0] lines;
    } qual_t;

    qual_t q_d, q_q;
    logic  take;

    assign take = q_q.open && pc_edge && (!gate_mode || hs_level);

    always_comb begin
        q_d = q_q;
        if (take) begin
            q_d.sof_pend = 1'b0;
            q_d.sol_pend = 1'b0;
        end
        if (!cap_en) begin
            q_d.open     = 1'b0;
            q_d.sof_pend = 1'b0;
            q_d.sol_pend = 1'b0;
        end else begin
            if (vs_edge) begin
                q_d.open     = 1'b1;
                q_d.sof_pend = 1'b1;
                q_d.sol_pend = 1'b0;
                q_d.frames   = q_q.frames + 1'b1;
                q_d.lines    = '0;
            end
            if (gate_mode && hs_edge && q_d.open) begin
                q_d.sol_pend = 1'b1;
                q_d.lines    = q_d.lines + 1'b1;
            end
        end
        q_d.ovf = (q_q.ovf && !ovf_clr) || (take && buf_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign wr_en    = take && !buf_full;
    assign wr_word  = {q_q.sof_pend, gate_mode & q_q.sol_pend, pix};
    assign ovf      = q_q.ovf;
    assign frames   = q_q.frames;
    assign lines    = q_q.lines;
    assign in_frame = q_q.open;

endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             not_empty,
    output logic             full
);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign not_empty = (p_q.wp != p_q.rp);
    assign full      = (p_q.wp[AW] != p_q.rp[AW]) && (p_q.wp[AW-1:0] == p_q.rp[AW-1:0]);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign dout      = mem[p_q.rp[AW-1:0]];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp[AW-1:0]] <= din;
    end

endmodule

// File: rtl/cam_capture.sv
module cam_capture #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              gate_mode,
    input  logic              vs_inv,
    input  logic              hs_inv,
    input  logic              pclk_fall,
    input  logic              sen_vsync,
    input  logic              sen_hsync,
    input  logic              sen_pclk,
    input  logic [DATA_W-1:0] sen_data,
    input  logic              rd_en,
    output logic [DATA_W+1:0] rd_data,
    output logic              rd_valid,
    output logic              fifo_full,
    output logic              ovf_flag,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic [CNT_W-1:0]  line_cnt,
    output logic              frame_active
);
    localparam int unsigned WORD_W = DATA_W + 2;

    logic              vs_edge, hs_edge, hs_level, pc_edge;
    logic [DATA_W-1:0] pix;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;

    cam_sync #(.DATA_W(DATA_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .vs_in    (sen_vsync),
        .hs_in    (sen_hsync),
        .pc_in    (sen_pclk),
        .data_in  (sen_data),
        .vs_inv   (vs_inv),
        .hs_inv   (hs_inv),
        .pc_inv   (pclk_fall),
        .vs_edge  (vs_edge),
        .hs_edge  (hs_edge),
        .hs_level (hs_level),
        .pc_edge  (pc_edge),
        .data_out (pix)
    );

    cam_qual #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .gate_mode (gate_mode),
        .vs_edge   (vs_edge),
        .hs_edge   (hs_edge),
        .hs_level  (hs_level),
        .pc_edge   (pc_edge),
        .pix       (pix),
        .buf_full  (fifo_full),
        .ovf_clr   (ovf_clr),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .ovf       (ovf_flag),
        .frames    (frame_cnt),
        .lines     (line_cnt),
        .in_frame  (frame_active)
    );

    cam_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .din       (wr_word),
        .pop       (rd_en),
        .dout      (rd_data),
        .not_empty (rd_valid),
        .full      (fifo_full)
    );

endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             gate_mode,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             fifo_full,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] frame_cnt,
    input logic [CNT_W-1:0] line_cnt,
    input logic             frame_active
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag); // R7

    AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(fifo_full)); // R7

    AST_DRAIN_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> $past(rd_en)); // R6

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1)); // R1

    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> line_cnt <= CNT_W'(1)); // R1

    AST_CLOSED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> !frame_active); // R2

    AST_NO_LINES_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_mode |=> ($stable(line_cnt) || !$stable(frame_cnt))); // R4

endmodule

bind cam_capture cam_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (cap_en),
    .gate_mode    (gate_mode),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .fifo_full    (fifo_full),
    .ovf_flag     (ovf_flag),
    .ovf_clr      (ovf_clr),
    .frame_cnt    (frame_cnt),
    .line_cnt     (line_cnt),
    .frame_active (frame_active)
);

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
    localparam int DATA_W = 10;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 0, gate_mode = 0, vs_inv = 0, hs_inv = 0, pclk_fall = 0;
    logic sen_vsync = 0, sen_hsync = 0, sen_pclk = 0;
    logic [DATA_W-1:0] sen_data = '0;
    logic rd_en = 0, ovf_clr = 0;
    logic [DATA_W+1:0] rd_data;
    logic rd_valid, fifo_full, ovf_flag, frame_active;
    logic [CNT_W-1:0] frame_cnt, line_cnt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cam_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

    // fields: {hs_level, stored, sof, sol, pixel[9:0]}
    localparam logic [13:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 10'h011},
        {1'b1, 1'b1, 1'b1, 1'b1, 10'h122},
        {1'b1, 1'b1, 1'b0, 1'b0, 10'h233},
        {1'b0, 1'b0, 1'b0, 1'b0, 10'h344},
        {1'b1, 1'b1, 1'b0, 1'b1, 10'h055},
        {1'b1, 1'b1, 1'b0, 1'b0, 10'h3AA},
        {1'b0, 1'b0, 1'b0, 1'b0, 10'h166},
        {1'b1, 1'b1, 1'b0, 1'b1, 10'h2F0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_start();
        sen_vsync = vs_inv; wait_cyc(4);
        sen_vsync = ~vs_inv; wait_cyc(4);
        sen_vsync = vs_inv; wait_cyc(4);
    endtask

    task automatic pix(input logic hs_lvl, input logic [DATA_W-1:0] d);
        sen_hsync = hs_lvl ^ hs_inv; wait_cyc(2);
        sen_data = d;
        sen_pclk = ~pclk_fall; wait_cyc(3);
        sen_pclk = pclk_fall; wait_cyc(4);
    endtask

    task automatic pop_check(input string req, input logic [DATA_W+1:0] exp);
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, {20'd0, rd_data}, {20'd0, exp});
        rd_en = 1'b1; wait_cyc(1); rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
        // reset state R6 R7 R1
        check("R6 reset empty", {31'd0, rd_valid}, 32'd0);
        check("R7 reset ovf", {31'd0, ovf_flag}, 32'd0);
        check("R1 reset frames", {16'd0, frame_cnt}, 32'd0);

        // R2: no frame start yet, sample discarded
        cap_en = 1'b1; wait_cyc(2);
        pix(1'b1, 10'h0AB);
        check("R2 pre-frame discard", {31'd0, rd_valid}, 32'd0);

        // R3 table: gated frame
        gate_mode = 1'b1;
        frame_start();
        check("R1 frame count", {16'd0, frame_cnt}, 32'd1);
        for (int i = 0; i < 8; i++) begin
            pix(VEC[i][13], VEC[i][9:0]);
            if (VEC[i][12]) pop_check("R3 gated sample", VEC[i][11:0]);
            else check("R3 gated idle", {31'd0, rd_valid}, 32'd0);
        end
        check("R3 line count", {16'd0, line_cnt}, 32'd3);

        // R4: non-gated
        gate_mode = 1'b0;
        pix(1'b0, 10'h000); // closes hs without new frame; stored in current frame
        pop_check("R4 ungated hs low", {2'b00, 10'h000});
        frame_start();
        check("R1 second frame", {16'd0, frame_cnt}, 32'd2);
        check("R1 line cleared", {16'd0, line_cnt}, 32'd0);
        pix(1'b0, 10'h101);
        pop_check("R4 first ungated", {2'b10, 10'h101});
        pix(1'b1, 10'h102);
        pop_check("R4 hs ignored", {2'b00, 10'h102});
        check("R4 lines held", {16'd0, line_cnt}, 32'd0);

        // R5: inverted polarity on all controls
        gate_mode = 1'b1;
        vs_inv = 1'b1; hs_inv = 1'b1; pclk_fall = 1'b1; wait_cyc(2);
        sen_vsync = 1'b1; sen_hsync = 1'b1; sen_pclk = 1'b1; wait_cyc(4);
        check("R5 no spurious frame", {16'd0, frame_cnt}, 32'd2);
        frame_start();
        check("R5 falling vsync frame", {16'd0, frame_cnt}, 32'd3);
        pix(1'b1, 10'h2C3);
        pop_check("R5 inverted sample", {2'b11, 10'h2C3});
        pix(1'b0, 10'h0F0);
        check("R5 low-active hs gates", {31'd0, rd_valid}, 32'd0);
        vs_inv = 1'b0; hs_inv = 1'b0; pclk_fall = 1'b0; wait_cyc(2);
        sen_vsync = 1'b0; sen_hsync = 1'b0; sen_pclk = 1'b0; wait_cyc(4);

        // R7: overflow, R6 order
        gate_mode = 1'b0;
        frame_start();
        for (int k = 0; k < DEPTH; k++) pix(1'b0, 10'h300 + 10'(k));
        check("R7 full", {31'd0, fifo_full}, 32'd1);
        check("R7 no ovf yet", {31'd0, ovf_flag}, 32'd0);
        pix(1'b0, 10'h3FF);
        check("R7 ovf set", {31'd0, ovf_flag}, 32'd1);
        for (int k = 0; k < DEPTH; k++)
            pop_check("R6 order", {(k == 0) ? 2'b10 : 2'b00, 10'h300 + 10'(k)});
        check("R7 drop", {31'd0, rd_valid}, 32'd0);
        check("R7 sticky", {31'd0, ovf_flag}, 32'd1);
        ovf_clr = 1'b1; wait_cyc(1); ovf_clr = 1'b0;
        check("R7 cleared", {31'd0, ovf_flag}, 32'd0);

        // R2: disable ends frame
        cap_en = 1'b0; wait_cyc(1);
        check("R2 frame closed", {31'd0, frame_active}, 32'd0);
        pix(1'b0, 10'h111);
        check("R2 disabled drop", {31'd0, rd_valid}, 32'd0);
        cap_en = 1'b1; wait_cyc(1);
        pix(1'b0, 10'h112);
        check("R2 wait for frame", {31'd0, rd_valid}, 32'd0);
        frame_start();
        pix(1'b0, 10'h113);
        pop_check("R2 resumed", {2'b10, 10'h113});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule